// File: doc/BRIEF.md
# Electrically Erasable Byte-Wide Read-Only Memory Model

This block is a synthesizable cycle-based model of a byte-wide memory that is read like a classic mask or UV-erasable part but is written electrically. Three active-low controls (chip select, output gate and write strobe), address bit 0, and discrete codes for the programming supply, the core supply and a high-voltage flag on a dedicated address line choose one of several operating modes. The model keeps its contents in an internal array and drives a three-state data bus only in the modes that read something out.

Writes are one-directional. A programming strobe can only turn ones into zeros, because the new byte is the AND of the old byte and the bus value. Only a whole-array erase can bring bits back to one. With the high-voltage flag raised and the programming supply at its normal level, the bus returns two fixed identification bytes instead of array data. A parameter can add a fixed number of clock cycles of access delay to the read path.

Top module: `eeprom_model`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) sets every array byte to 8'hFF, and a read after reset returns 8'hFF at any address.
- R2: While ce_n is high, bus_en is 0 and dq is not driven, whatever oe_n and pgm_n do. A strobe in this state does not change the array.
- R3: With ce_n low, oe_n low, vpp_lvl = 2'b00 and a9_hv low, the bus drives the byte stored at addr. With ce_n low and oe_n high in this supply state, bus_en is 0.
- R4: With vpp_lvl = 2'b01, vcc_prog high, ce_n low and oe_n high, a clock edge that samples pgm_n low, after the previous edge sampled it high, stores (old byte AND dq) at addr.
- R5: Programming never sets a bit. Bits already 0 stay 0 when a 1 is presented for them.
- R6: With vpp_lvl = 2'b10, vcc_prog high, a9_hv high, addr[0] low, ce_n low and oe_n high, a strobe edge sets every array byte to 8'hFF.
- R7: An erase strobe with addr[0] high or a9_hv low leaves the array unchanged.
- R8: With vpp_lvl = 2'b01 or 2'b10, ce_n low, oe_n low and pgm_n high, the bus drives the byte stored at addr (verify read).
- R9: With vpp_lvl = 2'b00, a9_hv high, ce_n low and oe_n low, the bus returns 8'hDA when addr[0] is 0 and 8'h01 when addr[0] is 1.
- R10: A strobe in any mode other than program or erase, for example output disable at normal supply, leaves the array unchanged.
- R11: A strobe counts only after pgm_n has been sampled high since reset. If pgm_n is held low out of reset, nothing is written.
- R12: A program strobe with vcc_prog low leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset, fills the array with ones |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program/erase strobe |
| vpp_lvl | input | 2 | Programming supply code: 00 normal, 01 program level, 10 erase level, 11 treated as normal |
| vcc_prog | input | 1 | Core supply raised to its programming level |
| a9_hv | input | 1 | High voltage present on the identification address line |
| addr | input | ADDR_W | Byte address |
| dq | inout | DATA_W | Three-state data bus |
| bus_en | output | 1 | High while the model drives dq |

## Verification
A wrong mode decode shows up at the ports in the same cycle: bus_en rises or falls against the control inputs, or the identification bytes appear in place of array data. A faulty write path, such as an OR instead of an AND, a missed edge qualifier or a partial erase, stays hidden until the affected byte is read back. The bench therefore follows each strobe with a verify or normal read one cycle later, and it reads a byte that should be untouched after each strobe that must be ignored.

// File: rtl/eeprom_pkg.sv
// Package: shared codes and mode encoding for the electrically erasable memory model.
// Assumes a byte-oriented identification scheme (two fixed 8-bit codes).
package eeprom_pkg;

    // Discrete programming-supply levels presented on vpp_lvl
    typedef enum logic [1:0] {
        VPP_NORM  = 2'd0,
        VPP_PROG  = 2'd1,
        VPP_ERASE = 2'd2,
        VPP_RSVD  = 2'd3
    } vpp_code_e;

    // Operating modes after decode
    typedef enum logic [3:0] {
        M_STANDBY   = 4'd0,
        M_OUT_DIS   = 4'd1,
        M_READ      = 4'd2,
        M_PROG      = 4'd3,
        M_PROG_VFY  = 4'd4,
        M_ERASE     = 4'd5,
        M_ERASE_VFY = 4'd6,
        M_ID_MFR    = 4'd7,
        M_ID_DEV    = 4'd8
    } mode_e;

    localparam logic [7:0] MFR_ID   = 8'hDA;
    localparam logic [7:0] DEV_ID   = 8'h01;

endpackage

// File: rtl/eeprom_mode_dec.sv
// Module: eeprom_mode_dec
// Purely combinational decode of control pins and supply codes into one mode.
// Assumes: ce_n high wins over everything; reserved supply code acts as normal.
module eeprom_mode_dec
    import eeprom_pkg::*;
(
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       pgm_n,
    input  logic [1:0] vpp_lvl,
    input  logic       vcc_prog,
    input  logic       a9_hv,
    input  logic       a0,
    output mode_e      mode,
    output logic       wr_mode,
    output logic       rd_array,
    output logic       rd_id
);

    // Select the operating mode from pins and supply codes
    always_comb begin
        mode = M_OUT_DIS;
        if (ce_n) begin
            mode = M_STANDBY;
        end else begin
            unique case (vpp_code_e'(vpp_lvl))
                VPP_PROG: begin
                    if (oe_n && vcc_prog)      mode = M_PROG;
                    else if (!oe_n && pgm_n)   mode = M_PROG_VFY;
                    else                       mode = M_OUT_DIS;
                end
                VPP_ERASE: begin
                    if (oe_n && vcc_prog && a9_hv && !a0) mode = M_ERASE;
                    else if (!oe_n && pgm_n)              mode = M_ERASE_VFY;
                    else                                  mode = M_OUT_DIS;
                end
                default: begin
                    if (oe_n)       mode = M_OUT_DIS;
                    else if (a9_hv) mode = a0 ? M_ID_DEV : M_ID_MFR;
                    else            mode = M_READ;
                end
            endcase
        end
    end

    // Group modes into the classes the datapath needs
    always_comb begin
        wr_mode  = (mode == M_PROG) || (mode == M_ERASE);
        rd_array = (mode == M_READ) || (mode == M_PROG_VFY) || (mode == M_ERASE_VFY);
        rd_id    = (mode == M_ID_MFR) || (mode == M_ID_DEV);
    end

endmodule

// File: rtl/eeprom_strobe.sv
// Module: eeprom_strobe
// Detects a high-to-low transition of the active-low strobe as sampled by clk.
// Assumes: the strobe must be seen high after reset before a transition counts.
module eeprom_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic pgm_n,
    output logic fire
);

    logic pgm_hi_q;

    // Remember whether the strobe was high at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) pgm_hi_q <= 1'b0;
        else        pgm_hi_q <= pgm_n;
    end

    // A fire is a low sample right after a high one
    always_comb fire = pgm_hi_q && !pgm_n;

endmodule

// File: rtl/eeprom_array.sv
// Module: eeprom_array
// Byte storage with AND-only programming and whole-array erase to ones.
// Assumes: erase and program are exclusive (guaranteed by the mode decode).
module eeprom_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Fill with ones on reset or erase, clear bits on program
    always_ff @(posedge clk) begin
        if (!rst_n || erase_en) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (prog_en) begin
            cells[addr] <= cells[addr] & wdata;
        end
    end

    // Asynchronous read of the addressed byte
    always_comb rdata = cells[addr];

endmodule

// File: rtl/eeprom_out_stage.sv
// Module: eeprom_out_stage
// Chooses array or identifier data and optionally delays it by ACC_CYC clocks.
// Assumes: ACC_CYC of 0 gives a purely combinational output path.
module eeprom_out_stage
    import eeprom_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_array,
    input  logic              rd_id,
    input  logic              a0,
    input  logic [DATA_W-1:0] arr_data,
    output logic              drv_en,
    output logic [DATA_W-1:0] drv_data
);

    logic              sel_en;
    logic [DATA_W-1:0] sel_data;

    // Pick the source of the outgoing byte
    always_comb begin
        sel_en   = rd_array || rd_id;
        sel_data = arr_data;
        if (rd_id) sel_data = a0 ? DATA_W'(DEV_ID) : DATA_W'(MFR_ID);
    end

    generate
        if (ACC_CYC == 0) begin : g_direct
            // Pass the selection straight to the bus
            always_comb begin
                drv_en   = sel_en;
                drv_data = sel_data;
            end
        end else begin : g_delay
            logic              en_q   [ACC_CYC];
            logic [DATA_W-1:0] data_q [ACC_CYC];

            // Shift enable and data through the access-delay stages
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < ACC_CYC; i++) begin
                        en_q[i]   <= 1'b0;
                        data_q[i] <= '0;
                    end
                end else begin
                    en_q[0]   <= sel_en;
                    data_q[0] <= sel_data;
                    for (int i = 1; i < ACC_CYC; i++) begin
                        en_q[i]   <= en_q[i-1];
                        data_q[i] <= data_q[i-1];
                    end
                end
            end

            // Present the last stage
            always_comb begin
                drv_en   = en_q[ACC_CYC-1];
                drv_data = data_q[ACC_CYC-1];
            end
        end
    endgenerate

endmodule

// File: rtl/eeprom_model.sv
// Module: eeprom_model (top)
// Byte-wide electrically erasable memory model with a three-state bus.
// Assumes: analog levels arrive as discrete codes; writes act on the clock
// edge that samples a falling strobe while a write mode is decoded.
module eeprom_model
    import eeprom_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic [1:0]        vpp_lvl,
    input  logic              vcc_prog,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] dq,
    output logic              bus_en
);

    mode_e             mode;
    logic              wr_mode;
    logic              rd_array;
    logic              rd_id;
    logic              fire;
    logic              prog_en;
    logic              erase_en;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] drv_data;

    eeprom_mode_dec u_dec (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .pgm_n    (pgm_n),
        .vpp_lvl  (vpp_lvl),
        .vcc_prog (vcc_prog),
        .a9_hv    (a9_hv),
        .a0       (addr[0]),
        .mode     (mode),
        .wr_mode  (wr_mode),
        .rd_array (rd_array),
        .rd_id    (rd_id)
    );

    eeprom_strobe u_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .pgm_n (pgm_n),
        .fire  (fire)
    );

    // Qualify the strobe with the decoded write mode
    always_comb begin
        prog_en  = fire && wr_mode && (mode == M_PROG);
        erase_en = fire && wr_mode && (mode == M_ERASE);
    end

    eeprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .addr     (addr),
        .wdata    (dq),
        .rdata    (arr_rd)
    );

    eeprom_out_stage #(
        .DATA_W  (DATA_W),
        .ACC_CYC (ACC_CYC)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_array (rd_array),
        .rd_id    (rd_id),
        .a0       (addr[0]),
        .arr_data (arr_rd),
        .drv_en   (bus_en),
        .drv_data (drv_data)
    );

    // Drive the bus only when a read mode is active
    assign dq = bus_en ? drv_data : 'z;

endmodule

// File: rtl/eeprom_model_chk.sv
// Module: eeprom_model_chk
// Property checker bound to eeprom_model. Keeps its own strobe history so
// the write checks do not reuse the design's edge detector.
module eeprom_model_chk #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic [1:0]        vpp_lvl,
    input  logic              vcc_prog,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq,
    input  logic              bus_en,
    input  logic [DATA_W-1:0] arr_rd
);

    logic pgm_seen_hi;
    logic edge_lo;
    logic prog_ok;
    logic erase_ok;
    logic erase_bad_a0;

    // Track the previous strobe level independently
    always_ff @(posedge clk) begin
        if (!rst_n) pgm_seen_hi <= 1'b0;
        else        pgm_seen_hi <= pgm_n;
    end

    // Conditions of a qualifying strobe, written from the requirements
    always_comb begin
        edge_lo      = pgm_seen_hi && !pgm_n;
        prog_ok      = edge_lo && !ce_n && oe_n && vcc_prog && (vpp_lvl == 2'b01);
        erase_ok     = edge_lo && !ce_n && oe_n && vcc_prog && (vpp_lvl == 2'b10)
                       && a9_hv && !addr[0];
        erase_bad_a0 = edge_lo && !ce_n && oe_n && vcc_prog && (vpp_lvl == 2'b10)
                       && a9_hv && addr[0];
    end

    // R4
    prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |=> (!$stable(addr) || arr_rd == ($past(arr_rd) & $past(dq))));

    // R5
    prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |=> (!$stable(addr) || (arr_rd & ~$past(arr_rd)) == '0));

    // R6
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_ok |=> (arr_rd == '1));

    // R7
    erase_a0_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_bad_a0 |=> (!$stable(addr) || $stable(arr_rd)));

    // R2
    standby_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_lo && ce_n) |=> (!$stable(addr) || $stable(arr_rd)));

    // R12
    vcc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_lo && !ce_n && oe_n && !vcc_prog) |=> (!$stable(addr) || $stable(arr_rd)));

    generate
        if (ACC_CYC == 0) begin : g_port_chk
            // R2
            standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ce_n |-> !bus_en);

            // R3
            oe_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n && oe_n && vpp_lvl == 2'b00) |-> !bus_en);

            // R9
            id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n && !oe_n && vpp_lvl == 2'b00 && a9_hv && !addr[0])
                |-> (bus_en && dq == DATA_W'(8'hDA)));

            // R9
            id_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n && !oe_n && vpp_lvl == 2'b00 && a9_hv && addr[0])
                |-> (bus_en && dq == DATA_W'(8'h01)));

            // R8
            verify_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n && !oe_n && pgm_n && (vpp_lvl == 2'b01 || vpp_lvl == 2'b10))
                |-> (bus_en && dq == arr_rd));
        end
    endgenerate

endmodule

bind eeprom_model eeprom_model_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ACC_CYC (ACC_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .pgm_n    (pgm_n),
    .vpp_lvl  (vpp_lvl),
    .vcc_prog (vcc_prog),
    .a9_hv    (a9_hv),
    .addr     (addr),
    .dq       (dq),
    .bus_en   (bus_en),
    .arr_rd   (arr_rd)
);

// File: tb/eeprom_model_bench.sv
`timescale 1ns/100ps
module eeprom_model_bench;

    localparam int AW = 10;
    localparam int DW = 8;

    typedef struct packed {
        logic          ce_n;
        logic          oe_n;
        logic          pgm_n;
        logic [1:0]    vpp;
        logic          vccp;
        logic          a9;
        logic [AW-1:0] addr;
        logic [DW-1:0] din;
        logic          drv;
        logic          exp_en;
        logic [DW-1:0] exp_d;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 31;
    // fields: ce oe pgm vpp vccp a9 addr din drv exp_en exp_d req
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b1,2'd0,1'b0,1'b0,10'h005,8'h00,1'b0,1'b0,8'h00,4'd2},  // R2 standby
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,10'h005,8'h00,1'b0,1'b1,8'hFF,4'd1},  // R1 blank read
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,10'h3FF,8'h00,1'b0,1'b1,8'hFF,4'd1},  // R1 top address
        '{1'b0,1'b1,1'b1,2'd0,1'b0,1'b0,10'h005,8'h00,1'b0,1'b0,8'h00,4'd3},  // R3 output off
        '{1'b0,1'b1,1'b1,2'd1,1'b1,1'b0,10'h005,8'hA5,1'b1,1'b0,8'h00,4'd4},  // R4 setup
        '{1'b0,1'b1,1'b0,2'd1,1'b1,1'b0,10'h005,8'hA5,1'b1,1'b0,8'h00,4'd4},  // R4 strobe
        '{1'b0,1'b1,1'b1,2'd1,1'b1,1'b0,10'h005,8'hA5,1'b1,1'b0,8'h00,4'd4},  // R4 release
        '{1'b0,1'b0,1'b1,2'd1,1'b1,1'b0,10'h005,8'h00,1'b0,1'b1,8'hA5,4'd8},  // R8 verify
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,10'h005,8'h00,1'b0,1'b1,8'hA5,4'd3},  // R3 read back
        '{1'b0,1'b1,1'b1,2'd1,1'b1,1'b0,10'h005,8'h5A,1'b1,1'b0,8'h00,4'd5},  // R5 setup
        '{1'b0,1'b1,1'b0,2'd1,1'b1,1'b0,10'h005,8'h5A,1'b1,1'b0,8'h00,4'd5},  // R5 strobe
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,10'h005,8'h00,1'b0,1'b1,8'h00,4'd5},  // R5 AND result
        '{1'b0,1'b1,1'b1,2'd1,1'b0,1'b0,10'h007,8'h0F,1'b1,1'b0,8'h00,4'd12}, // R12 setup
        '{1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,10'h007,8'h0F,1'b1,1'b0,8'h00,4'd12}, // R12 strobe
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,10'h007,8'h00,1'b0,1'b1,8'hFF,4'd12}, // R12 unchanged
        '{1'b1,1'b1,1'b1,2'd1,1'b1,1'b0,10'h008,8'h00,1'b1,1'b0,8'h00,4'd2},  // R2 setup
        '{1'b1,1'b1,1'b0,2'd1,1'b1,1'b0,10'h008,8'h00,1'b1,1'b0,8'h00,4'd2},  // R2 strobe
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,10'h008,8'h00,1'b0,1'b1,8'hFF,4'd2},  // R2 unchanged
        '{1'b0,1'b1,1'b1,2'd0,1'b1,1'b0,10'h009,8'h00,1'b1,1'b0,8'h00,4'd10}, // R10 setup
        '{1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,10'h009,8'h00,1'b1,1'b0,8'h00,4'd10}, // R10 strobe
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,10'h009,8'h00,1'b0,1'b1,8'hFF,4'd10}, // R10 unchanged
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b1,10'h000,8'h00,1'b0,1'b1,8'hDA,4'd9},  // R9 maker code
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b1,10'h001,8'h00,1'b0,1'b1,8'h01,4'd9},  // R9 device code
        '{1'b0,1'b1,1'b1,2'd2,1'b1,1'b1,10'h001,8'hFF,1'b1,1'b0,8'h00,4'd7},  // R7 setup
        '{1'b0,1'b1,1'b0,2'd2,1'b1,1'b1,10'h001,8'hFF,1'b1,1'b0,8'h00,4'd7},  // R7 strobe a0=1
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,10'h005,8'h00,1'b0,1'b1,8'h00,4'd7},  // R7 not erased
        '{1'b0,1'b1,1'b1,2'd2,1'b1,1'b1,10'h000,8'hFF,1'b1,1'b0,8'h00,4'd6},  // R6 setup
        '{1'b0,1'b1,1'b0,2'd2,1'b1,1'b1,10'h000,8'hFF,1'b1,1'b0,8'h00,4'd6},  // R6 strobe
        '{1'b0,1'b0,1'b1,2'd2,1'b1,1'b0,10'h005,8'h00,1'b0,1'b1,8'hFF,4'd6},  // R6 erase verify
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,10'h005,8'h00,1'b0,1'b1,8'hFF,4'd6},  // R6 read
        '{1'b0,1'b0,1'b1,2'd1,1'b1,1'b0,10'h009,8'h00,1'b0,1'b1,8'hFF,4'd8}   // R8 program verify
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, pgm_n, vccp, a9;
    logic [1:0]    vpp;
    logic [AW-1:0] addr;
    logic [DW-1:0] tb_d;
    logic          tb_drv;
    logic          bus_en;
    wire  [DW-1:0] dq;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    assign dq = tb_drv ? tb_d : 'z;

    always #2.5 clk = ~clk;

    eeprom_model #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYC(0)) u_eeprom_model (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .pgm_n    (pgm_n),
        .vpp_lvl  (vpp),
        .vcc_prog (vccp),
        .a9_hv    (a9),
        .addr     (addr),
        .dq       (dq),
        .bus_en   (bus_en)
    );

    task automatic check(input int req, input logic exp_en, input logic [DW-1:0] exp_d);
        checks++;
        if (bus_en !== exp_en || (exp_en && dq !== exp_d)) begin
            failures++;
            $display("FAIL R%0d: bus_en=%0b dq=%02h expected bus_en=%0b dq=%02h",
                     req, bus_en, dq, exp_en, exp_d);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        ce_n = v.ce_n; oe_n = v.oe_n; pgm_n = v.pgm_n; vpp = v.vpp;
        vccp = v.vccp; a9 = v.a9; addr = v.addr; tb_d = v.din; tb_drv = v.drv;
        @(posedge clk);
        #1;
    endtask

    function automatic vec_t mk(input logic c, input logic o, input logic p,
                                input logic [1:0] vp, input logic vc,
                                input logic [AW-1:0] a, input logic [DW-1:0] d,
                                input logic dv);
        vec_t v;
        v = '{c, o, p, vp, vc, 1'b0, a, d, dv, 1'b0, 8'h00, 4'd0};
        return v;
    endfunction

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp = 2'd0;
        vccp = 1'b0; a9 = 1'b0; addr = '0; tb_d = '0; tb_drv = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check(1, 1'b0, 8'h00);  // R1 bus idle in reset
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check(int'(VECS[i].req), VECS[i].exp_en, VECS[i].exp_d);
        end

        // R1: program address 4 to zero, then reset must restore ones
        apply(mk(1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 10'h004, 8'h00, 1'b1));
        apply(mk(1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 10'h004, 8'h00, 1'b1));
        apply(mk(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 10'h004, 8'h00, 1'b0));
        check(4, 1'b1, 8'h00);  // R4 written before reset

        // R11: strobe held low through reset in program mode
        apply(mk(1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 10'h002, 8'h00, 1'b1));
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(11, 1'b0, 8'h00);  // R11 program mode, bus idle
        apply(mk(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 10'h002, 8'h00, 1'b0));
        check(11, 1'b1, 8'hFF);  // R11 no write from held strobe
        apply(mk(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 10'h004, 8'h00, 1'b0));
        check(1, 1'b1, 8'hFF);   // R1 reset refilled ones

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule